// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry half of processor exception handling. Other logic raises a request and supplies a class, a vector number and, for interrupts, the level. The core also supplies its current program counter, status word and supervisor stack pointer. The block takes a copy of the status word and forms the updated status word. For every class except reset, it then pushes a four-word short frame onto the supervisor stack, one 16-bit word at a time. Next it reads the handler address from the vector table. Finally it returns the new program counter, the new stack pointer and the new status word to the core.

Reset entry takes a different path. It pushes nothing and clears the vector base. It then reads four words starting at address zero: the first longword becomes the stack pointer and the second becomes the program counter. All memory traffic goes over a word-wide request/acknowledge port. The vector base can be loaded by the core while the sequencer is idle.

Top module: `excSeqTop`

## Requirements
- R1: A request (excReq high) is accepted only when busy is low, and busy is high from the next cycle until the entry ends. Requests and vector-base writes that arrive while busy is high have no effect.
- R2: The new status word is the captured status word with bit 15 (trace) cleared and bit 13 (supervisor) set. All other bits keep their values, except those changed under R3.
- R3: The mask field is bits 10:8. Class 2'b01 (interrupt) loads it with excLevel, class 2'b00 (reset) forces it to 7, and classes 2'b10 and 2'b11 leave it unchanged.
- R4: A non-reset entry makes exactly four word writes, each to the current stack pointer minus 2. Before each write the stack pointer drops by 2. The words go in this order: frame word at SSP-2, program counter bits 15:0 at SSP-4, program counter bits 31:16 at SSP-6, and the captured status word at SSP-8. newSp ends at SSP-8.
- R5: In the frame word, bits 15:12 hold the format code 4'b0000 and bits 11:0 hold vector×4.
- R6: The handler address is read from vectorBase + vector×4 (high word) and then from the next word address (low word). newPc is {high, low}.
- R7: A reset-class entry makes no writes and clears the vector base. It reads addresses 0 and 2 into newSp (high word, then low word) and addresses 4 and 6 into newPc.
- R8: A vector-base write (vbrWe) is taken only while the sequencer is idle. It moves the vector table for later entries.
- R9: done is high for exactly one cycle, after the last vector word is loaded. newPc, newSp and newSr are valid from that cycle onward.
- R10: memReq stays high with memAddr and memWe unchanged until memAck. Every address is even.
- R11: After block reset, busy, done and memReq are low and the vector base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| excReq | input | 1 | Exception request |
| excClass | input | 2 | 0 reset, 1 interrupt, 2 trap, 3 other |
| excVector | input | VEC_W | Vector number |
| excLevel | input | 3 | Interrupt level for class 1 |
| curPc | input | 32 | Program counter to save |
| curSr | input | 16 | Status word at entry |
| curSsp | input | 32 | Supervisor stack pointer at entry |
| vbrWe | input | 1 | Vector base write strobe |
| vbrWdata | input | 32 | Vector base write value |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | One-cycle completion of the request |
| memRdata | input | 16 | Read data, valid with memAck |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle end-of-entry pulse |
| newPc | output | 32 | Handler program counter |
| newSp | output | 32 | Resulting supervisor stack pointer |
| newSr | output | 16 | Resulting status word |

## Verification
The bench builds the block with the default VEC_W of 8. This allows vector 255, whose offset 0x3FC fills the offset field up to bit 9, alongside small vectors and vector bases of 0, 0x100 and 0x200. Its memory model inserts a selectable number of wait cycles before each acknowledge, so both back-to-back and stalled handshakes are exercised.

// File: rtl/excSeqPkg.sv
package excSeqPkg;

  typedef enum logic [1:0] {
    CLS_RESET = 2'd0,
    CLS_IRQ   = 2'd1,
    CLS_TRAP  = 2'd2,
    CLS_OTHER = 2'd3
  } excClass_e;

  localparam int WORD_W     = 16;
  localparam int LONG_W     = 32;
  localparam int SR_TRACE   = 15;
  localparam int SR_SUPER   = 13;
  localparam int SR_MASK_LO = 8;
  localparam int OFF_W      = 12;
  localparam int FRAME_WORDS = 4;

  localparam logic [3:0] FMT_SHORT = 4'b0000;

  // strobes from control to datapath
  typedef struct packed {
    logic       idle;
    logic       capture;
    logic       pushing;
    logic       reading;
    logic       wrDone;
    logic       rdDone;
    logic [1:0] step;
  } dpCtl_t;

endpackage

// File: rtl/excSeqCtrl.sv
module excSeqCtrl
  import excSeqPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         excReq,
  input  logic [1:0]   excClass,
  input  logic         memAck,
  output logic         memReq,
  output logic         memWe,
  output logic         busy,
  output logic         done,
  output dpCtl_t       dpCtl
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_READ = 2'd2,
    ST_FIN  = 2'd3
  } state_e;

  localparam logic [1:0] LAST_PUSH     = 2'(FRAME_WORDS - 1);
  localparam logic [1:0] LAST_RD_RESET = 2'd3;
  localparam logic [1:0] LAST_RD_VEC   = 2'd1;

  state_e     state;
  logic [1:0] step;
  logic       rstMode;
  logic       accept;
  logic [1:0] lastRead;

  assign accept   = (state == ST_IDLE) && excReq;
  assign lastRead = rstMode ? LAST_RD_RESET : LAST_RD_VEC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      step    <= '0;
      rstMode <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            step    <= '0;
            rstMode <= (excClass == CLS_RESET);
            state   <= (excClass == CLS_RESET) ? ST_READ : ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (memAck) begin
            if (step == LAST_PUSH) begin
              step  <= '0;
              state <= ST_READ;
            end else begin
              step <= step + 2'd1;
            end
          end
        end
        ST_READ: begin
          if (memAck) begin
            if (step == lastRead) begin
              step  <= '0;
              state <= ST_FIN;
            end else begin
              step <= step + 2'd1;
            end
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memReq        = (state == ST_PUSH) || (state == ST_READ);
    memWe         = (state == ST_PUSH);
    busy          = (state != ST_IDLE);
    done          = (state == ST_FIN);
    dpCtl.idle    = (state == ST_IDLE);
    dpCtl.capture = accept;
    dpCtl.pushing = (state == ST_PUSH);
    dpCtl.reading = (state == ST_READ);
    dpCtl.wrDone  = (state == ST_PUSH) && memAck;
    dpCtl.rdDone  = (state == ST_READ) && memAck;
    dpCtl.step    = step;
  end

endmodule

// File: rtl/excSeqDatapath.sv
module excSeqDatapath
  import excSeqPkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [1:0]         excClass,
  input  logic [VEC_W-1:0]   excVector,
  input  logic [2:0]         excLevel,
  input  logic [LONG_W-1:0]  curPc,
  input  logic [WORD_W-1:0]  curSr,
  input  logic [LONG_W-1:0]  curSsp,
  input  logic               vbrWe,
  input  logic [LONG_W-1:0]  vbrWdata,
  input  logic [WORD_W-1:0]  memRdata,
  output logic [LONG_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memWdata,
  output logic [LONG_W-1:0]  newPc,
  output logic [LONG_W-1:0]  newSp,
  output logic [WORD_W-1:0]  newSr
);

  localparam int VOFF_W = VEC_W + 2;
  localparam logic [LONG_W-1:0] WORD_BYTES = LONG_W'(WORD_W / 8);

  logic               isRst;
  logic [VEC_W-1:0]   vecNum;
  logic [WORD_W-1:0]  srCopy;
  logic [LONG_W-1:0]  pcSave;
  logic [LONG_W-1:0]  spReg;
  logic [LONG_W-1:0]  pcReg;
  logic [WORD_W-1:0]  srReg;
  logic [LONG_W-1:0]  vbrReg;

  logic [VOFF_W-1:0]  vecOff;
  logic [LONG_W-1:0]  vecBase;
  logic [1:0]         rdIdx;
  logic [WORD_W-1:0]  frameWord;

  function automatic logic [WORD_W-1:0] enterSr(
    input logic [WORD_W-1:0] sr,
    input logic [1:0]        cls,
    input logic [2:0]        lvl
  );
    logic [WORD_W-1:0] r;
    r = sr;
    r[SR_TRACE] = 1'b0;
    r[SR_SUPER] = 1'b1;
    if (cls == CLS_RESET)     r[SR_MASK_LO +: 3] = 3'd7;
    else if (cls == CLS_IRQ)  r[SR_MASK_LO +: 3] = lvl;
    return r;
  endfunction

  assign vecOff    = {vecNum, 2'b00};
  assign vecBase   = vbrReg + LONG_W'(vecOff);
  assign rdIdx     = isRst ? ctl.step : ctl.step + 2'd2;
  assign frameWord = {FMT_SHORT, OFF_W'(vecOff)};

  // context capture and status update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isRst  <= 1'b0;
      vecNum <= '0;
      srCopy <= '0;
      pcSave <= '0;
      srReg  <= '0;
    end else if (ctl.capture) begin
      isRst  <= (excClass == CLS_RESET);
      vecNum <= (excClass == CLS_RESET) ? '0 : excVector;
      srCopy <= curSr;
      pcSave <= curPc;
      srReg  <= enterSr(curSr, excClass, excLevel);
    end
  end

  // vector base
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbrReg <= '0;
    end else if (ctl.capture && (excClass == CLS_RESET)) begin
      vbrReg <= '0;
    end else if (ctl.idle && !ctl.capture && vbrWe) begin
      vbrReg <= vbrWdata;
    end
  end

  // stack pointer: decremented per push, loaded by reset reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spReg <= '0;
    end else if (ctl.capture) begin
      spReg <= curSsp;
    end else if (ctl.wrDone) begin
      spReg <= spReg - WORD_BYTES;
    end else if (ctl.rdDone && rdIdx == 2'd0) begin
      spReg[LONG_W-1:WORD_W] <= memRdata;
    end else if (ctl.rdDone && rdIdx == 2'd1) begin
      spReg[WORD_W-1:0] <= memRdata;
    end
  end

  // handler program counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg <= '0;
    end else if (ctl.rdDone && rdIdx == 2'd2) begin
      pcReg[LONG_W-1:WORD_W] <= memRdata;
    end else if (ctl.rdDone && rdIdx == 2'd3) begin
      pcReg[WORD_W-1:0] <= memRdata;
    end
  end

  always_comb begin
    memAddr = '0;
    if (ctl.pushing)      memAddr = spReg - WORD_BYTES;
    else if (ctl.reading) memAddr = vecBase + LONG_W'({ctl.step, 1'b0});
  end

  always_comb begin
    unique case (ctl.step)
      2'd0:    memWdata = frameWord;
      2'd1:    memWdata = pcSave[WORD_W-1:0];
      2'd2:    memWdata = pcSave[LONG_W-1:WORD_W];
      default: memWdata = srCopy;
    endcase
  end

  assign newPc = pcReg;
  assign newSp = spReg;
  assign newSr = srReg;

endmodule

// File: rtl/excSeqTop.sv
module excSeqTop
  import excSeqPkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [1:0]        excClass,
  input  logic [VEC_W-1:0]  excVector,
  input  logic [2:0]        excLevel,
  input  logic [31:0]       curPc,
  input  logic [15:0]       curSr,
  input  logic [31:0]       curSsp,
  input  logic              vbrWe,
  input  logic [31:0]       vbrWdata,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [15:0]       memWdata,
  input  logic              memAck,
  input  logic [15:0]       memRdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       newPc,
  output logic [31:0]       newSp,
  output logic [15:0]       newSr
);

  dpCtl_t dpCtl;

  excSeqCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .excReq   (excReq),
    .excClass (excClass),
    .memAck   (memAck),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .done     (done),
    .dpCtl    (dpCtl)
  );

  excSeqDatapath #(.VEC_W(VEC_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .excClass  (excClass),
    .excVector (excVector),
    .excLevel  (excLevel),
    .curPc     (curPc),
    .curSr     (curSr),
    .curSsp    (curSsp),
    .vbrWe     (vbrWe),
    .vbrWdata  (vbrWdata),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .newPc     (newPc),
    .newSp     (newSp),
    .newSr     (newSr)
  );

endmodule

// File: rtl/excSeqChecker.sv
module excSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        excReq,
  input logic [1:0]  excClass,
  input logic        busy,
  input logic        done,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [15:0] newSr
);

  logic rstMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rstMode <= 1'b0;
    else if (excReq && !busy) rstMode <= (excClass == 2'd0);
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    excReq && !busy |=> busy);  // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));  // R10

  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !memAddr[0]);  // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9

  AST_SUPER_ON: assert property (@(posedge clk) disable iff (!rstN)
    done |-> newSr[13] && !newSr[15]);  // R2

  AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rstMode && memReq |-> !memWe);  // R7

  AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rstN)
    rstMode && done |-> newSr[10:8] == 3'd7);  // R3

endmodule

bind excSeqTop excSeqChecker uChk (.*);

// File: tb/tb_excSeqTop.sv
module tb_excSeqTop;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  cls;
    logic [7:0]  vec;
    logic [2:0]  lvl;
    logic [31:0] pc;
    logic [15:0] sr;
    logic [31:0] ssp;
    logic [31:0] vbr;
    logic [3:0]  stall;
  } tcase_t;

  localparam int NCASE = 5;
  localparam tcase_t TV [NCASE] = '{
    '{2'd2, 8'd32,  3'd0, 32'h0001_2346, 16'h8005, 32'h0000_0700, 32'h0000_0000, 4'd0},
    '{2'd1, 8'd26,  3'd2, 32'h0000_1000, 16'h0000, 32'h0000_0780, 32'h0000_0000, 4'd2},
    '{2'd1, 8'd64,  3'd7, 32'hABCD_0010, 16'hA700, 32'h0000_07F0, 32'h0000_0100, 4'd1},
    '{2'd3, 8'd4,   3'd5, 32'h0000_0FFE, 16'h2300, 32'h0000_0600, 32'h0000_0200, 4'd3},
    '{2'd2, 8'd255, 3'd1, 32'hFFFF_FFFE, 16'h0015, 32'h0000_07E0, 32'h0000_0000, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [1:0]  excClass = '0;
  logic [7:0]  excVector = '0;
  logic [2:0]  excLevel = '0;
  logic [31:0] curPc = '0;
  logic [15:0] curSr = '0;
  logic [31:0] curSsp = '0;
  logic        vbrWe = 1'b0;
  logic [31:0] vbrWdata = '0;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic        busy, done;
  logic [31:0] newPc, newSp;
  logic [15:0] newSr;

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [15:0] mem [0:1023];
  int          stall = 0;
  int          stallCnt = 0;
  int          wrCount = 0;
  int          addrErr = 0;
  logic [31:0] firstAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excSeqTop dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excClass(excClass),
    .excVector(excVector), .excLevel(excLevel), .curPc(curPc), .curSr(curSr),
    .curSsp(curSsp), .vbrWe(vbrWe), .vbrWdata(vbrWdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .busy(busy), .done(done), .newPc(newPc),
    .newSp(newSp), .newSr(newSr)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
      stallCnt = 0;
    end else if (memReq && !memAck) begin
      if (stallCnt == 0) firstAddr = memAddr;
      if (stallCnt >= stall) begin
        if (memAddr != firstAddr) addrErr = addrErr + 1;
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr[10:1]] = memWdata;
          wrCount = wrCount + 1;
        end else begin
          memRdata <= mem[memAddr[10:1]];
        end
        stallCnt = 0;
      end else begin
        stallCnt = stallCnt + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expSr(input logic [1:0] cls, input logic [15:0] sr,
                                        input logic [2:0] lvl);
    logic [15:0] r;
    r = sr;
    r[15] = 1'b0;
    r[13] = 1'b1;
    if (cls == 2'd0)      r[10:8] = 3'd7;
    else if (cls == 2'd1) r[10:8] = lvl;
    return r;
  endfunction

  task automatic setVbr(input logic [31:0] v);
    @(negedge clk);
    vbrWe = 1'b1; vbrWdata = v;
    @(negedge clk);
    vbrWe = 1'b0;
  endtask

  task automatic fire(input logic [1:0] cls, input logic [7:0] vec, input logic [2:0] lvl,
                      input logic [31:0] pc, input logic [15:0] sr, input logic [31:0] ssp);
    @(negedge clk);
    excReq = 1'b1; excClass = cls; excVector = vec; excLevel = lvl;
    curPc = pc; curSr = sr; curSsp = ssp;
    @(negedge clk);
    excReq = 1'b0;
  endtask

  task automatic waitDone(output int width);
    width = 0;
    for (int k = 0; k < 400 && !done; k++) @(negedge clk);
    while (done) begin
      width++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    int wr0;
    logic [31:0] va;
    logic [31:0] hpc;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R11: state under block reset
    check("R11 busy", 32'(busy), 0);
    check("R11 done", 32'(done), 0);
    check("R11 memReq", 32'(memReq), 0);
    rstN = 1'b1;

    // table-driven entries
    for (int i = 0; i < NCASE; i++) begin
      stall = int'(TV[i].stall);
      setVbr(TV[i].vbr);
      va  = TV[i].vbr + {22'd0, TV[i].vec, 2'b00};
      hpc = {8'h5A, 8'(i), 8'h3C, TV[i].vec};
      mem[va[10:1]]       = hpc[31:16];
      mem[va[10:1] + 10'd1] = hpc[15:0];
      wr0 = wrCount;
      fire(TV[i].cls, TV[i].vec, TV[i].lvl, TV[i].pc, TV[i].sr, TV[i].ssp);
      waitDone(w);
      check("R6 newPc", newPc, hpc);
      check("R4 newSp", newSp, TV[i].ssp - 32'd8);
      check("R2 R3 newSr", 32'(newSr), 32'(expSr(TV[i].cls, TV[i].sr, TV[i].lvl)));
      check("R5 frame word", 32'(mem[(TV[i].ssp - 32'd2) >> 1]),
            {20'd0, 4'b0000, 2'b00, TV[i].vec, 2'b00});
      check("R4 pc low", 32'(mem[(TV[i].ssp - 32'd4) >> 1]), 32'(TV[i].pc[15:0]));
      check("R4 pc high", 32'(mem[(TV[i].ssp - 32'd6) >> 1]), 32'(TV[i].pc[31:16]));
      check("R4 saved sr", 32'(mem[(TV[i].ssp - 32'd8) >> 1]), 32'(TV[i].sr));
      check("R4 write count", 32'(wrCount - wr0), 32'd4);
      check("R9 done width", 32'(w), 32'd1);
      check("R10 address held", 32'(addrErr), 32'd0);
    end

    // R7: reset entry with a nonzero vector base beforehand
    stall = 1;
    setVbr(32'h0000_0100);
    mem[0] = 16'h0000; mem[1] = 16'h07C0; mem[2] = 16'h0000; mem[3] = 16'h4000;
    wr0 = wrCount;
    fire(2'd0, 8'h77, 3'd3, 32'h1234_5678, 16'h8015, 32'h0BAD_0000);
    waitDone(w);
    check("R7 reset newSp", newSp, 32'h0000_07C0);
    check("R7 reset newPc", newPc, 32'h0000_4000);
    check("R3 reset mask", 32'(newSr), 32'h0000_2715);
    check("R7 reset no writes", 32'(wrCount - wr0), 32'd0);
    check("R9 reset done width", 32'(w), 32'd1);

    // R7: vector base cleared -> vector 5 read from 0x14, not 0x114
    mem[10] = 16'h0000; mem[11] = 16'h2222;
    mem[138] = 16'hDEAD; mem[139] = 16'hBEEF;
    fire(2'd2, 8'd5, 3'd0, 32'h0000_0500, 16'h0000, 32'h0000_0680);
    waitDone(w);
    check("R7 base cleared", newPc, 32'h0000_2222);

    // R1 R8: requests and base writes during busy are ignored
    stall = 2;
    mem[12] = 16'h0000; mem[13] = 16'h3333;
    mem[(32'h500 - 32'd2) >> 1] = 16'hBEEF;
    wr0 = wrCount;
    fire(2'd2, 8'd6, 3'd0, 32'h0000_0010, 16'h0700, 32'h0000_0640);
    @(negedge clk);
    excReq = 1'b1; excVector = 8'd7; curSsp = 32'h0000_0500;
    vbrWe = 1'b1; vbrWdata = 32'h0000_0300;
    @(negedge clk);
    excReq = 1'b0; vbrWe = 1'b0;
    waitDone(w);
    check("R1 single entry writes", 32'(wrCount - wr0), 32'd4);
    check("R1 first request kept", newPc, 32'h0000_3333);
    check("R1 sp of first request", newSp, 32'h0000_0638);
    check("R1 second stack untouched", 32'(mem[(32'h500 - 32'd2) >> 1]), 32'h0000_BEEF);
    check("R1 idle after", 32'(busy), 32'd0);
    check("R3 trap keeps mask", 32'(newSr), 32'h0000_2700);
    fire(2'd2, 8'd6, 3'd0, 32'h0000_0010, 16'h0000, 32'h0000_0640);
    waitDone(w);
    check("R8 busy base write ignored", newPc, 32'h0000_3333);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule